// File: doc/BRIEF.md
# Link Status Register

This block holds the 16-bit status word of a serial point-to-point link port. Hardware events from the link training state machine and the data-link control machine latch two sticky bandwidth-event flags. Software clears each flag by writing 1 to its bit. Three read-only bits are driven live:

- the data-link-active state;
- a board strap that selects the clock source;
- a training-in-progress flag.

A small state machine tracks training. It keeps the training flag high from a software retrain request until training actually starts. It also recognises when a software-requested retrain completes.

Accesses come through one register select with read and write strobes. Read data is registered. A data-link-down pulse in the same cycle as a bandwidth event or a retrain completion discards that event.

The training tracker has four states:

| State | Meaning |
|---|---|
| `TR_IDLE` | No training |
| `TR_PEND` | Retrain requested, training not yet started |
| `TR_RETRAIN` | Training caused by a software request |
| `TR_HWTRAIN` | Training started by the link itself |

Its transitions are:

| From | Condition | To | Notes |
|---|---|---|---|
| `TR_IDLE` | request | `TR_PEND` | |
| `TR_IDLE` | training input high | `TR_HWTRAIN` | |
| `TR_PEND` | training input high | `TR_RETRAIN` | |
| `TR_HWTRAIN` | request while training | `TR_RETRAIN` | |
| `TR_HWTRAIN` | request as training drops | `TR_PEND` | |
| `TR_HWTRAIN` | training input low | `TR_IDLE` | |
| `TR_RETRAIN` | training input low | `TR_IDLE` | Emits a completion pulse |
| `TR_RETRAIN` | training input low with a new request | `TR_PEND` | Emits a completion pulse |

Top module: `lnk_status_reg`

## Requirements
- R1: After reset the registered read data is 0x1000, and a first read with strap high and no activity returns 0x1000.
- R2: Bit 15 is set by an autonomous bandwidth-change pulse and stays set until software clears it.
- R3: Bit 14 is set by a reliability bandwidth-change pulse, or when training ends in `TR_RETRAIN`. Training that ends in `TR_HWTRAIN` does not set it.
- R4: A retrain request made while the link is already training still sets bit 14 when that training ends.
- R5: A register write clears bit 15 or bit 14 where the write data bit is 1. A 0 in that position leaves the bit unchanged.
- R6: A set event and a write-1 clear on the same bit in the same cycle leave the bit set.
- R7: A link-down pulse in the same cycle as a set event for bit 15 or bit 14 blocks that set.
- R8: Bit 13 follows the data-link-active input when the capability parameter is 1, and reads 0 when it is 0.
- R9: Bit 12 follows the clock strap input.
- R10: Bit 11 reads 1 from the cycle after a retrain request until training ends, and while hardware training is in progress. It lags the training input by one cycle.
- R11: Bits 10 to 0 read 0, and writes to bits 13 to 0 have no effect.
- R12: Read data updates only on the clock edge where read strobe and register select are both high, and then holds. Writes without register select are ignored. A read and a clear in the same cycle return the value before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 1 | Register select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data, a 1 in bit 15 or 14 clears that bit |
| rd_data | output | 16 | Registered read data |
| retrain_req | input | 1 | One-cycle software retrain request |
| lt_in_train | input | 1 | Training machine is in Configuration or Recovery |
| bw_auto_evt | input | 1 | Autonomous speed/width change pulse |
| bw_rel_evt | input | 1 | Reliability-driven or non-autonomous change pulse |
| dl_down_evt | input | 1 | Data-link-down transition pulse |
| dll_active | input | 1 | Data-link control machine is active |
| clk_strap | input | 1 | 1 when the connector reference clock is used |

## Verification
On every cycle, the assertions check the following:

- the set-over-clear priority of the sticky bits;
- the link-down suppression of set events;
- that write-1 clears take effect;
- that a retrain request raises the training flag;
- that read data holds between reads.

Only the bench's scenarios can show how the flags combine:

- the full register value read back after event sequences;
- retrain completion after hardware training is taken over by a request;
- the capability-off variant;
- the value returned by a read that coincides with a clear.

// File: rtl/lnk_stat_pkg.sv
package lnk_stat_pkg;
    localparam int LS_W       = 16;
    localparam int POS_AUTO   = 15;
    localparam int POS_MGMT   = 14;
    localparam int POS_DLLA   = 13;
    localparam int POS_SCLK   = 12;
    localparam int POS_TRN    = 11;
    localparam int NUM_STICKY = 2;   // index 1 = bit 15, index 0 = bit 14
    localparam logic [LS_W-1:0] LS_RST = 16'h1000;

    typedef enum logic [1:0] {
        TR_IDLE    = 2'd0,
        TR_PEND    = 2'd1,
        TR_RETRAIN = 2'd2,
        TR_HWTRAIN = 2'd3
    } tr_state_e;
endpackage

// File: rtl/lnk_sticky_bit.sv
module lnk_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic kill_i,
    input  logic clr_i,
    output logic q_o
);
    logic set_ok;
    assign set_ok = set_i & ~kill_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (set_ok) q_o <= 1'b1;
        else if (clr_i)  q_o <= 1'b0;
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !kill_i && clr_i) |=> q_o);
    a_r7_kill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_o && kill_i) |=> !q_o);
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && clr_i && !(set_i && !kill_i)) |=> !q_o);
endmodule

// File: rtl/lnk_event_bits.sv
module lnk_event_bits
    import lnk_stat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STICKY-1:0] set_vec,
    input  logic [NUM_STICKY-1:0] clr_vec,
    input  logic                  link_down,
    output logic [NUM_STICKY-1:0] q_vec
);
    for (genvar g = 0; g < NUM_STICKY; g++) begin : g_bit
        lnk_sticky_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[g]),
            .kill_i (link_down),
            .clr_i  (clr_vec[g]),
            .q_o    (q_vec[g])
        );
    end
endmodule

// File: rtl/lnk_train_track.sv
module lnk_train_track
    import lnk_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic retrain_req,
    input  logic lt_in_train,
    output logic train_flag_o,
    output logic retrain_done_o
);
    tr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d        = state_q;
        retrain_done_o = 1'b0;
        unique case (state_q)
            TR_IDLE: begin
                if (retrain_req)      state_d = TR_PEND;
                else if (lt_in_train) state_d = TR_HWTRAIN;
            end
            TR_PEND: begin
                if (lt_in_train) state_d = TR_RETRAIN;
            end
            TR_HWTRAIN: begin
                if (retrain_req)       state_d = lt_in_train ? TR_RETRAIN : TR_PEND;
                else if (!lt_in_train) state_d = TR_IDLE;
            end
            TR_RETRAIN: begin
                if (!lt_in_train) begin
                    retrain_done_o = 1'b1;
                    state_d        = retrain_req ? TR_PEND : TR_IDLE;
                end
            end
            default: state_d = TR_IDLE;
        endcase
    end

    assign train_flag_o = (state_q != TR_IDLE);

    // R10: a retrain request always raises the training flag next cycle
    a_r10_req_flag: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_req |=> train_flag_o);
    // R10: a pending request holds until training begins
    a_r10_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TR_PEND && !lt_in_train) |=> (state_q == TR_PEND));
    // R3: completion only follows a period of training
    a_r3_done_after_train: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_done_o |-> $past(lt_in_train));
endmodule

// File: rtl/lnk_rd_port.sv
module lnk_rd_port
    import lnk_stat_pkg::*;
#(
    parameter bit DLLA_CAP = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_stb,
    input  logic [NUM_STICKY-1:0] sticky,
    input  logic                  dll_active,
    input  logic                  clk_strap,
    input  logic                  train_flag,
    output logic [LS_W-1:0]       rd_data
);
    logic [LS_W-1:0] word;
    logic            dlla_bit;

    if (DLLA_CAP) begin : g_dlla
        assign dlla_bit = dll_active;
    end else begin : g_nodlla
        logic unused_dll;
        assign unused_dll = dll_active;
        assign dlla_bit   = 1'b0;
    end

    always_comb begin
        word           = '0;
        word[POS_AUTO] = sticky[1];
        word[POS_MGMT] = sticky[0];
        word[POS_DLLA] = dlla_bit;
        word[POS_SCLK] = clk_strap;
        word[POS_TRN]  = train_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= LS_RST;
        else if (rd_stb) rd_data <= word;
    end

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    a_r9_strap_seen: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data[POS_SCLK] == $past(clk_strap)));
endmodule

// File: rtl/lnk_status_reg.sv
module lnk_status_reg
    import lnk_stat_pkg::*;
#(
    parameter bit DLLA_CAP = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_sel,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [LS_W-1:0] wr_data,
    output logic [LS_W-1:0] rd_data,
    input  logic            retrain_req,
    input  logic            lt_in_train,
    input  logic            bw_auto_evt,
    input  logic            bw_rel_evt,
    input  logic            dl_down_evt,
    input  logic            dll_active,
    input  logic            clk_strap
);
    logic                  wr_stb, rd_stb;
    logic                  train_flag, retrain_done;
    logic [NUM_STICKY-1:0] set_vec, clr_vec, sticky;

    assign wr_stb = wr_en & reg_sel;
    assign rd_stb = rd_en & reg_sel;

    lnk_train_track u_track (
        .clk            (clk),
        .rst_n          (rst_n),
        .retrain_req    (retrain_req),
        .lt_in_train    (lt_in_train),
        .train_flag_o   (train_flag),
        .retrain_done_o (retrain_done)
    );

    assign set_vec = {bw_auto_evt, bw_rel_evt | retrain_done};
    assign clr_vec = {wr_data[POS_AUTO], wr_data[POS_MGMT]} & {NUM_STICKY{wr_stb}};

    lnk_event_bits u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .link_down (dl_down_evt),
        .q_vec     (sticky)
    );

    lnk_rd_port #(.DLLA_CAP(DLLA_CAP)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .sticky     (sticky),
        .dll_active (dll_active),
        .clk_strap  (clk_strap),
        .train_flag (train_flag),
        .rd_data    (rd_data)
    );

    // R11: writing read-only positions without a read leaves read data alone
    a_r11_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (wr_data[POS_DLLA:0] != '0) && !rd_stb) |=> $stable(rd_data));
    // R2: an unsuppressed autonomous event is visible on the next read
    a_r2_auto_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_auto_evt && !dl_down_evt) |=> sticky[1]);
endmodule

// File: tb/lnk_status_reg_bench.sv
module lnk_status_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 0, rd_en = 0, wr_en = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data, rd_data_b;
    logic        retrain_req = 0, lt_in_train = 0, bw_auto_evt = 0, bw_rel_evt = 0;
    logic        dl_down_evt = 0, dll_active = 0, clk_strap = 1;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;  // 125 MHz

    lnk_status_reg u_lnk_status_reg (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .retrain_req(retrain_req),
        .lt_in_train(lt_in_train), .bw_auto_evt(bw_auto_evt), .bw_rel_evt(bw_rel_evt),
        .dl_down_evt(dl_down_evt), .dll_active(dll_active), .clk_strap(clk_strap));

    lnk_status_reg #(.DLLA_CAP(1'b0)) u_nocap (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data_b), .retrain_req(retrain_req),
        .lt_in_train(lt_in_train), .bw_auto_evt(bw_auto_evt), .bw_rel_evt(bw_rel_evt),
        .dl_down_evt(dl_down_evt), .dll_active(dll_active), .clk_strap(clk_strap));

    // {wr, wdata, auto, rel, down, retrain, in_train, dll, strap, expected}
    localparam int NV = 23;
    localparam logic [39:0] VEC [0:NV-1] = '{
        {1'b0, 16'h0000, 7'b0000001, 16'h1000},  // R1 R9 idle read
        {1'b0, 16'h0000, 7'b1000001, 16'h9000},  // R2 autonomous event
        {1'b0, 16'h0000, 7'b0000011, 16'hB000},  // R8 link active
        {1'b1, 16'h8000, 7'b0000011, 16'h3000},  // R5 clear bit 15
        {1'b0, 16'h0000, 7'b0100011, 16'h7000},  // R3 reliability event
        {1'b1, 16'h0000, 7'b0000011, 16'h7000},  // R5 write 0 keeps
        {1'b1, 16'hFFFF, 7'b0000011, 16'h3000},  // R11 RO bits untouched
        {1'b0, 16'h0000, 7'b1010011, 16'h3000},  // R7 link down blocks
        {1'b0, 16'h0000, 7'b0001011, 16'h3800},  // R10 pending retrain
        {1'b0, 16'h0000, 7'b0000111, 16'h3800},  // R10 retraining
        {1'b0, 16'h0000, 7'b0000011, 16'h7000},  // R3 retrain complete
        {1'b1, 16'h4000, 7'b0000000, 16'h0000},  // R9 strap low, R5
        {1'b0, 16'h0000, 7'b0000100, 16'h0800},  // R10 hardware training
        {1'b0, 16'h0000, 7'b0001100, 16'h0800},  // R4 request during training
        {1'b0, 16'h0000, 7'b0000000, 16'h4000},  // R4 completion sets 14
        {1'b1, 16'h4000, 7'b0100000, 16'h4000},  // R6 set beats clear
        {1'b1, 16'hC000, 7'b1000000, 16'h8000},  // R6 set 15, clear 14
        {1'b1, 16'hC000, 7'b0000000, 16'h0000},  // R5 clear both
        {1'b0, 16'h0000, 7'b0000100, 16'h0800},  // R10 hw training
        {1'b0, 16'h0000, 7'b0000000, 16'h0000},  // R3 hw end sets nothing
        {1'b0, 16'h0000, 7'b0001000, 16'h0800},  // R10 pending
        {1'b0, 16'h0000, 7'b0000100, 16'h0800},  // R10 retraining
        {1'b0, 16'h0000, 7'b0010000, 16'h0000}   // R7 completion killed
    };
    localparam int VREQ [0:NV-1] = '{1,2,8,5,3,5,11,7,10,10,3,9,10,4,4,6,6,5,10,3,10,10,7};

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_read();
        @(negedge clk); rd_en = 1; reg_sel = 1;
        @(negedge clk); rd_en = 0; reg_sel = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset value", rd_data, 16'h1000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VEC[i][39]; reg_sel = VEC[i][39]; wr_data = VEC[i][38:23];
            {bw_auto_evt, bw_rel_evt, dl_down_evt, retrain_req, lt_in_train, dll_active, clk_strap} = VEC[i][22:16];
            @(negedge clk);
            wr_en = 0; bw_auto_evt = 0; bw_rel_evt = 0; dl_down_evt = 0; retrain_req = 0;
            rd_en = 1; reg_sel = 1;
            @(negedge clk);
            rd_en = 0; reg_sel = 0;
            check($sformatf("R%0d vector %0d", VREQ[i], i), rd_data, VEC[i][15:0]);
        end

        // R12: no read strobe, read data holds
        clk_strap = 1;
        repeat (2) @(negedge clk);
        check("R12 hold without read", rd_data, 16'h0000);
        rd_en = 1; @(negedge clk); rd_en = 0;
        check("R12 read without select", rd_data, 16'h0000);
        do_read();
        check("R12 normal read", rd_data, 16'h1000);

        // R12: write without select is ignored
        bw_auto_evt = 1; @(negedge clk); bw_auto_evt = 0;
        wr_en = 1; wr_data = 16'h8000; @(negedge clk); wr_en = 0;
        do_read();
        check("R12 unselected write ignored", rd_data, 16'h9000);

        // R12 R5: read and clear together return pre-clear value
        rd_en = 1; reg_sel = 1; wr_en = 1; wr_data = 16'h8000;
        @(negedge clk); rd_en = 0; reg_sel = 0; wr_en = 0;
        check("R12 read with clear", rd_data, 16'h9000);
        do_read();
        check("R5 clear after read", rd_data, 16'h1000);

        // R8: capability off ties bit 13 low
        dll_active = 1;
        do_read();
        check("R8 capability on", rd_data, 16'h3000);
        check("R8 capability off", rd_data_b, 16'h1000);

        done = 1;
        finish_run();
    end
endmodule